// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single line. A programmable prescaler produces a sample tick every N+1 clocks. Each bit period spans 16 ticks in normal speed, or 8 ticks when the double-speed input is set, so the same baud rate needs roughly twice the divisor in double speed. The input first passes through a two-flop synchroniser. The receiver waits for a low level, checks that the start bit is still low at its centre, and then decides every following bit (data, parity and stop) by majority over three adjacent samples around the middle of the bit.

The receiver accepts 5 to 9 data bits, sent LSB first. Parity can be none, even or odd, and the frame can have one or two stop bits. A finished character goes into a one-entry buffer together with its frame-error and parity-error flags. These flags describe the buffered character, not the current state of the line. A read strobe empties the buffer. A character that finishes while the buffer still holds unread data is dropped, and an overrun flag is raised.

Top module: `uart_rx_vote`

## Requirements
- R1: The sample tick fires once every div_i+1 clocks. A bit lasts 16 ticks when double_speed_i=0 and 8 ticks when double_speed_i=1. A frame sent at that rate is received correctly in both modes.
- R2: Each bit value is the majority of the samples numbered 8, 9 and 10 of the bit (4, 5 and 6 in double speed). Sample 1 of the start bit is the tick that first sees the line low. A single corrupted sample inside that window does not change the received value.
- R3: A low level that is high again at the start bit's vote is rejected as noise. The receiver returns to idle, and valid_o does not rise.
- R4: len_sel_i sets the data length: 0..4 give 5..9 bits, and 5..7 give 9 bits. The bits arrive LSB first and are right-aligned in data_o. Bits of data_o above the length are 0.
- R5: par_mode_i selects the parity: 00 or 01 none, 10 even, 11 odd. When parity is on, parity_err_o is set for a character whose parity bit does not match.
- R6: A stop bit voted 0 sets frame_err_o for that character. With two_stop_i=1, both stop bits are checked. A character completes at the vote of its last stop bit.
- R7: valid_o rises in the clock after a character completes and stays high until read_i. A read_i pulse clears valid_o, frame_err_o and parity_err_o in the following clock. The error flags are only ever high together with valid_o.
- R8: If a character completes while valid_o=1 and read_i=0, that character is discarded, data_o is unchanged and overrun_o rises. Any read_i clears overrun_o.
- R9: rx_i reaches the sampler through two flip-flops, so the receiver sees a line change two clocks late.
- R10: After reset, valid_o, data_o, frame_err_o, parity_err_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| div_i | input | DIV_W | Prescaler divisor N; tick every N+1 clocks |
| double_speed_i | input | 1 | 1: 8 samples per bit, 0: 16 |
| len_sel_i | input | 3 | Data length select (0..4 gives 5..9 bits) |
| par_mode_i | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| two_stop_i | input | 1 | 1: two stop bits checked |
| read_i | input | 1 | Read strobe, empties the buffer |
| valid_o | output | 1 | Unread character in buffer |
| data_o | output | 9 | Buffered character, right-aligned |
| frame_err_o | output | 1 | Stop bit error of the buffered character |
| parity_err_o | output | 1 | Parity error of the buffered character |
| overrun_o | output | 1 | A character was lost to a full buffer |

## Verification
A wrong sample counter or a misplaced vote window shifts where each bit is decided. This shows up within one frame as a wrong data_o, a missed start, or valid_o rising on a different clock than the reference model predicts. A stuck state in the frame sequencer leaves valid_o low after a frame, or raises it a bit period early or late. An error in the buffer shows on the first overlapping character, as a changed data_o or a missing overrun_o. The bench compares every output against a behavioural model on every clock, so any divergence is reported in the cycle where it first appears.

// File: rtl/uart_rx_vote_pkg.sv
package uart_rx_vote_pkg;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned MAX_BITS = 9;
  localparam int unsigned CNT_W    = 5;
  localparam logic [CNT_W-1:0] OS_FULL = 5'd16;
  localparam logic [CNT_W-1:0] OS_HALF = 5'd8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;  // line idles high
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the period bounded when the divisor shrinks under a running count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_vote_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                rx_i,
  input  logic                double_i,
  input  logic [2:0]          len_sel_i,
  input  logic [1:0]          par_mode_i,
  input  logic                two_stop_i,
  output logic                commit_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                frame_err_o,
  output logic                parity_err_o
);
  rx_state_e           state_q;
  logic [CNT_W-1:0]    scnt_q;
  logic [3:0]          bit_q;
  logic [MAX_BITS-1:0] sh_q;
  logic [1:0]          vote_q;
  logic                stop_bad_q, par_bit_q;

  logic [CNT_W-1:0] os, v_lo, v_hi, k;
  logic [3:0]       nbits;
  logic             mj, par_en, last_stop;

  assign os        = double_i ? OS_HALF : OS_FULL;
  assign v_lo      = os >> 1;
  assign v_hi      = v_lo + 5'd2;
  assign k         = scnt_q + 5'd1;
  assign nbits     = (len_sel_i > 3'd4) ? 4'(MAX_BITS) : ({1'b0, len_sel_i} + 4'(MIN_BITS));
  assign par_en    = par_mode_i[1];
  assign mj        = maj3(vote_q[1], vote_q[0], rx_i);
  assign last_stop = (bit_q == {3'b000, two_stop_i});

  assign commit_o     = tick_i && (state_q == ST_STOP) && (k == v_hi) && last_stop;
  assign data_o       = sh_q;
  assign frame_err_o  = stop_bad_q | ~mj;
  assign parity_err_o = par_en & ((^sh_q) ^ par_bit_q ^ par_mode_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      scnt_q     <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      vote_q     <= '0;
      stop_bad_q <= 1'b0;
      par_bit_q  <= 1'b0;
    end else if (tick_i) begin
      if (state_q == ST_IDLE) begin
        if (!rx_i) begin
          state_q    <= ST_START;
          scnt_q     <= 5'd1;
          bit_q      <= '0;
          sh_q       <= '0;
          stop_bad_q <= 1'b0;
        end
      end else begin
        scnt_q <= (k == os) ? '0 : k;
        if (k == v_lo || k == v_lo + 5'd1) vote_q <= {vote_q[0], rx_i};
        unique case (state_q)
          ST_START: begin
            if (k == v_hi && mj) state_q <= ST_IDLE;  // noise, not a start
            else if (k == os)    state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (k == v_hi) begin
              for (int i = 0; i < MAX_BITS; i++)
                if (bit_q == 4'(i)) sh_q[i] <= mj;
            end
            if (k == os) begin
              if (bit_q == nbits - 4'd1) begin
                bit_q   <= '0;
                state_q <= par_en ? ST_PAR : ST_STOP;
              end else begin
                bit_q <= bit_q + 4'd1;
              end
            end
          end
          ST_PAR: begin
            if (k == v_hi) par_bit_q <= mj;
            if (k == os)   state_q   <= ST_STOP;
          end
          ST_STOP: begin
            if (k == v_hi) begin
              if (!mj)      stop_bad_q <= 1'b1;
              if (last_stop) state_q   <= ST_IDLE;
            end else if (k == os) begin
              bit_q <= bit_q + 4'd1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf #(
  parameter int unsigned DW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [DW-1:0] data_i,
  input  logic          fe_i,
  input  logic          pe_i,
  input  logic          read_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          ovr_o
);
  logic accept;
  assign accept = commit_i && (!valid_o || read_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      if (commit_i && valid_o && !read_i) ovr_o <= 1'b1;
      else if (read_i)                    ovr_o <= 1'b0;
      if (accept) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
        fe_o    <= fe_i;
        pe_o    <= pe_i;
      end else if (read_i) begin
        valid_o <= 1'b0;
        fe_o    <= 1'b0;
        pe_o    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote
  import uart_rx_vote_pkg::*;
#(
  parameter int unsigned DIV_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic                double_speed_i,
  input  logic [2:0]          len_sel_i,
  input  logic [1:0]          par_mode_i,
  input  logic                two_stop_i,
  input  logic                read_i,
  output logic                valid_o,
  output logic [MAX_BITS-1:0] data_o,
  output logic                frame_err_o,
  output logic                parity_err_o,
  output logic                overrun_o
);
  logic                rx_s, tick, commit, fr_fe, fr_pe;
  logic [MAX_BITS-1:0] fr_data;

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(rx_s)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .tick_o(tick)
  );

  uart_rx_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx_s),
    .double_i(double_speed_i), .len_sel_i(len_sel_i), .par_mode_i(par_mode_i),
    .two_stop_i(two_stop_i), .commit_o(commit), .data_o(fr_data),
    .frame_err_o(fr_fe), .parity_err_o(fr_pe)
  );

  uart_rx_buf #(.DW(MAX_BITS)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .commit_i(commit), .data_i(fr_data),
    .fe_i(fr_fe), .pe_i(fr_pe), .read_i(read_i), .valid_o(valid_o),
    .data_o(data_o), .fe_o(frame_err_o), .pe_o(parity_err_o), .ovr_o(overrun_o)
  );
endmodule

// File: rtl/uart_rx_vote_chk.sv
module uart_rx_vote_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       read_i,
  input logic       commit,
  input logic       valid_o,
  input logic [8:0] data_o,
  input logic       frame_err_o,
  input logic       parity_err_o,
  input logic       overrun_o
);
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_err_o || parity_err_o) |-> valid_o);  // R7
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !read_i) |=> valid_o);  // R7
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && read_i && !commit) |=> (!valid_o && !overrun_o));  // R7
  AST_RISE_FROM_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(commit));  // R7
  AST_OVR_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !read_i && commit) |=> (overrun_o && $stable(data_o)));  // R8
  AST_OVR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !read_i) |=> overrun_o);  // R8
endmodule

bind uart_rx_vote uart_rx_vote_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .read_i(read_i), .commit(commit),
  .valid_o(valid_o), .data_o(data_o), .frame_err_o(frame_err_o),
  .parity_err_o(parity_err_o), .overrun_o(overrun_o)
);

// File: tb/uart_rx_vote_bench.sv
module uart_rx_vote_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [11:0] div = 12'd3;
  logic       ds = 1'b0;
  logic [2:0] len = 3'd3;
  logic [1:0] pm = 2'b00;
  logic       two = 1'b0;
  logic       rd = 1'b0;
  logic       valid, fe, pe, ovr;
  logic [8:0] data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  uart_rx_vote u_uart_rx_vote (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .div_i(div), .double_speed_i(ds),
    .len_sel_i(len), .par_mode_i(pm), .two_stop_i(two), .read_i(rd),
    .valid_o(valid), .data_o(data), .frame_err_o(fe), .parity_err_o(pe),
    .overrun_o(ovr)
  );

  // behavioural reference model
  int m_cnt, m_s1, m_s2, m_st, m_scnt, m_bit, m_v0, m_v1, m_sb, m_pb;
  int os, vlo, vhi, k, nb, mj, fe_c, pe_c, cm;
  bit [8:0] m_sh, m_dat;
  int m_valid, m_fe, m_pe, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_s1 = 1; m_s2 = 1; m_st = 0; m_scnt = 0; m_bit = 0;
      m_v0 = 0; m_v1 = 0; m_sb = 0; m_pb = 0; m_sh = 0; m_dat = 0;
      m_valid = 0; m_fe = 0; m_pe = 0; m_ovr = 0;
    end else begin
      cm = 0; fe_c = 0; pe_c = 0;
      if (m_cnt >= int'(div)) begin
        m_cnt = 0;
        os = ds ? 8 : 16; vlo = os / 2; vhi = vlo + 2; k = m_scnt + 1;
        nb = (len > 4) ? 9 : int'(len) + 5;
        mj = ((m_v1 + m_v0 + m_s2) >= 2) ? 1 : 0;
        if (m_st == 0) begin
          if (m_s2 == 0) begin m_st = 1; m_scnt = 1; m_sh = 0; m_sb = 0; m_bit = 0; end
        end else begin
          m_scnt = (k == os) ? 0 : k;
          case (m_st)
            1: if (k == vhi && mj == 1) m_st = 0; else if (k == os) m_st = 2;
            2: begin
              if (k == vhi) m_sh[m_bit] = mj[0];
              if (k == os) begin
                if (m_bit == nb - 1) begin m_bit = 0; m_st = pm[1] ? 3 : 4; end
                else m_bit++;
              end
            end
            3: begin
              if (k == vhi) m_pb = mj;
              if (k == os) m_st = 4;
            end
            default: begin
              if (k == vhi) begin
                fe_c = (m_sb == 1 || mj == 0) ? 1 : 0;
                pe_c = (pm[1] && (((^m_sh) ^ m_pb[0] ^ pm[0]) == 1'b1)) ? 1 : 0;
                if (m_bit == (two ? 1 : 0)) begin cm = 1; m_st = 0; end
                if (mj == 0) m_sb = 1;
              end else if (k == os) m_bit++;
            end
          endcase
          if (k == vlo || k == vlo + 1) begin m_v1 = m_v0; m_v0 = m_s2; end
        end
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (cm == 1 && m_valid == 1 && !rd) m_ovr = 1;
      else if (rd) m_ovr = 0;
      if (cm == 1 && (m_valid == 0 || rd)) begin
        m_valid = 1; m_dat = m_sh; m_fe = fe_c; m_pe = pe_c;
      end else if (rd) begin
        m_valid = 0; m_fe = 0; m_pe = 0;
      end
      m_s2 = m_s1; m_s1 = int'(rx);
    end
  end

  // per-clock comparison against the model (R1/R2/R3/R9 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (int'(valid) != m_valid || data != m_dat || int'(fe) != m_fe ||
          int'(pe) != m_pe || int'(ovr) != m_ovr) begin
        fails++;
        $display("FAIL R1/R9 model t=%0t act v=%0d d=%h fe=%0d pe=%0d ov=%0d exp v=%0d d=%h fe=%0d pe=%0d ov=%0d",
                 $time, valid, data, fe, pe, ovr, m_valid, m_dat, m_fe, m_pe, m_ovr);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input bit lvl, input bit glitch);
    int t  = int'(div) + 1;
    int bc = t * (ds ? 8 : 16);
    int h  = t * (ds ? 4 : 8);
    if (!glitch) begin
      repeat (bc) begin @(negedge clk); rx = lvl; end
    end else begin
      repeat (h)          begin @(negedge clk); rx = lvl;  end
      repeat (t)          begin @(negedge clk); rx = ~lvl; end
      repeat (bc - h - t) begin @(negedge clk); rx = lvl;  end
    end
  endtask

  // glitch_at: frame bit index (0 start, 1.. data) to corrupt one sample, -1 none
  task automatic send(input bit [8:0] d, input bit bad_par, input bit bad_s1,
                      input bit bad_s2, input int glitch_at);
    int nbl = (len > 4) ? 9 : int'(len) + 5;
    bit p = 1'b0;
    for (int i = 0; i < nbl; i++) p ^= d[i];
    if (pm == 2'b11) p = ~p;
    drive_bit(1'b0, glitch_at == 0);
    for (int i = 0; i < nbl; i++) drive_bit(d[i], glitch_at == i + 1);
    if (pm[1]) drive_bit(p ^ bad_par, 1'b0);
    drive_bit(~bad_s1, 1'b0);
    if (two) drive_bit(~bad_s2, 1'b0);
    drive_bit(1'b1, 1'b0);
  endtask

  task automatic do_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk("R7 valid after read", int'(valid), 0);
    chk("R7 flags after read", int'(fe | pe), 0);
  endtask

  task automatic expect_char(input string tag, input int d, input int efe, input int epe);
    chk({tag, " valid"}, int'(valid), 1);
    chk({tag, " data"},  int'(data), d);
    chk({tag, " frame_err"}, int'(fe), efe);
    chk({tag, " parity_err"}, int'(pe), epe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid", int'(valid), 0);
    chk("R10 data", int'(data), 0);
    chk("R10 flags", int'(fe | pe | ovr), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    len = 3'd3; pm = 2'b00; two = 1'b0;
    send(9'h0A5, 0, 0, 0, -1);
    expect_char("R1 8N1", 9'h0A5, 0, 0);
    do_read();

    len = 3'd0;
    send(9'h1FB, 0, 0, 0, -1);
    expect_char("R4 5bit upper zero", 9'h01B, 0, 0);
    do_read();

    len = 3'd4; pm = 2'b10;
    send(9'h1C3, 0, 0, 0, -1);
    expect_char("R4 R5 9bit even", 9'h1C3, 0, 0);
    do_read();

    len = 3'd7;
    send(9'h155, 1, 0, 0, -1);
    expect_char("R4 R5 len7 even bad", 9'h155, 0, 1);
    do_read();

    len = 3'd2; pm = 2'b11;
    send(9'h055, 0, 0, 0, -1);
    expect_char("R5 odd ok", 9'h055, 0, 0);
    do_read();
    send(9'h055, 1, 0, 0, -1);
    expect_char("R5 odd bad", 9'h055, 0, 1);
    do_read();

    pm = 2'b01; len = 3'd3;
    send(9'h0C3, 0, 0, 0, -1);
    expect_char("R5 mode01 none", 9'h0C3, 0, 0);
    do_read();

    pm = 2'b00;
    send(9'h03C, 0, 1, 0, -1);
    expect_char("R6 stop low", 9'h03C, 1, 0);
    do_read();

    two = 1'b1;
    send(9'h081, 0, 0, 1, -1);
    expect_char("R6 second stop low", 9'h081, 1, 0);
    do_read();
    send(9'h07E, 0, 0, 0, -1);
    expect_char("R6 two stop ok", 9'h07E, 0, 0);
    do_read();
    two = 1'b0;

    send(9'h0B4, 0, 0, 0, 4);
    expect_char("R2 glitch data bit", 9'h0B4, 0, 0);
    do_read();
    send(9'h0E1, 0, 0, 0, 0);
    expect_char("R2 glitch start bit", 9'h0E1, 0, 0);
    do_read();

    // R3 short low pulse
    repeat (3 * (int'(div) + 1)) begin @(negedge clk); rx = 1'b0; end
    repeat (40 * (int'(div) + 1)) begin @(negedge clk); rx = 1'b1; end
    chk("R3 noise start rejected", int'(valid), 0);

    ds = 1'b1; div = 12'd7;
    repeat (40) @(negedge clk);
    send(9'h03C, 0, 0, 0, -1);
    expect_char("R1 double speed", 9'h03C, 0, 0);
    do_read();
    send(9'h0D2, 0, 0, 0, 6);
    expect_char("R2 double glitch", 9'h0D2, 0, 0);
    do_read();
    ds = 1'b0; div = 12'd3;
    repeat (40) @(negedge clk);

    send(9'h011, 0, 0, 0, -1);
    send(9'h022, 0, 0, 0, -1);
    expect_char("R8 first kept", 9'h011, 0, 0);
    chk("R8 overrun set", int'(ovr), 1);
    do_read();
    chk("R8 overrun cleared", int'(ovr), 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule